// File: doc/BRIEF.md
# Multi-Plane LED Matrix Row Scanner

This block drives an LED matrix of 8 rows by 16 columns. It lights one row at a time and steps through the rows in turn. It keeps four frame buffers (planes) of pixel data and shows one of them. A host writes an 8-bit panel setup register, a row dwell register and the pixel memory over a simple register write port, which has a write strobe, an address and a data word. The setup register controls three things: the run/shutdown state, pixel polarity and the choice of plane.

Every row and column output has an enable beside it. The pad logic uses these enables to tri-state the drivers. In shutdown every enable is low and the scan stops where it is. Nothing the host has written is lost, and the scan continues from the same point when it resumes. Plane and polarity changes made while the scan runs are held back until the next frame begins, so a frame never shows half of one plane and half of another. Changes made during shutdown take effect as soon as the scan resumes.

Top module: `led_plane_scan`

## Requirements
- R1: After reset the setup register is 0x00. All row and column enables are low, and `row_drv` selects the first row (bit 0).
- R2: The setup register is at address 0x0D, and its bit 0 is the run bit. A write with bit 0 clear drives every enable low from the next cycle on. A write with bit 0 set drives every enable high from the next cycle on.
- R3: While the run bit is clear, `row_drv` and the row dwell count hold their values. When the run bit is set again, the scan continues from the held row. Plane, polarity and dwell settings are the same as before shutdown.
- R4: `row_drv` is one-hot, and bit 0 is the first row. Each row stays selected for a fixed number of cycles. The selection then moves to the next higher bit, and from bit 7 it returns to bit 0.
- R5: The dwell register is at address 0x0E and takes the low 12 data bits. Each row stays selected for the register value plus one cycles. The register resets to 3, which gives 4 cycles per row.
- R6: Pixel memory is written at address 0x20 + plane*8 + row, so plane is address bits 4:3 and row is address bits 2:0. The data is 16 bits, and data bit c feeds `col_drv[c]`.
- R7: Setup bit 1 sets polarity. When it is 0, `col_drv` equals the stored row of the shown plane. When it is 1, `col_drv` is the bitwise inverse of that row.
- R8: Setup bits 3:2 choose the plane, and bit 7 is a two-plane fold. Codes 0 and 1 show planes 0 and 1. Code 2 shows plane 2, or plane 0 if bit 7 is set. Code 3 shows plane 3, or plane 1 if bit 7 is set.
- R9: While running, a new plane or polarity setting appears only when the selection returns to bit 0. Until then the current frame keeps its old setting. A setting written during shutdown is shown on the first cycle after the scan resumes.
- R10: Writes to any address other than 0x0D, 0x0E or the pixel range 0x20 to 0x3F change nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 16 | Register write data |
| row_drv | output | 8 | One-hot row select |
| row_oe | output | 8 | Row driver enables |
| col_drv | output | 16 | Column pixel data for the selected row |
| col_oe | output | 16 | Column driver enables |

## Verification
A wrong row index or dwell count is visible at the ports within one row period. The symptom is a selection that is not one-hot, a step that skips a row, or a row held for the wrong number of cycles. A wrong plane or polarity shadow shows up at the first sample of the next frame as column data that does not match the plane pattern. Each plane is loaded with its own row pattern so that a swapped plane cannot pass unseen. A scan that fails to freeze shows up as `row_drv` moving while the enables are low. Lost settings show up as a changed plane, polarity or row period once the scan resumes.

// File: rtl/led_plane_scan.sv
module led_plane_scan #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int AW = 8,
  parameter int DWELL_W = 12,
  parameter int DWELL_RST = 3,
  parameter logic [AW-1:0] CFG_ADDR = 8'h0D,
  parameter logic [AW-1:0] DWELL_ADDR = 8'h0E,
  parameter logic [AW-1:0] MEM_BASE = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [COLS-1:0] reg_wdata,
  output logic [ROWS-1:0] row_drv,
  output logic [ROWS-1:0] row_oe,
  output logic [COLS-1:0] col_drv,
  output logic [COLS-1:0] col_oe
);
  localparam int RW = $clog2(ROWS);
  localparam int PLANES = 4;

  logic [7:0]         cfg, cfg_d;
  logic [DWELL_W-1:0] dwell, cnt;
  logic [RW-1:0]      row;
  logic [1:0]         sh_plane;
  logic               sh_inv;
  logic [COLS-1:0]    mem [PLANES][ROWS];

  wire cfg_hit   = reg_we && reg_addr == CFG_ADDR;
  wire dwell_hit = reg_we && reg_addr == DWELL_ADDR;
  wire mem_hit   = reg_we && reg_addr[AW-1:RW+2] == MEM_BASE[AW-1:RW+2]
                   && int'(reg_addr[RW-1:0]) < ROWS;

  assign cfg_d = cfg_hit ? reg_wdata[7:0] : cfg;

  wire       run       = cfg[0];
  wire [1:0] pick      = {cfg_d[3] & ~cfg_d[7], cfg_d[2]};
  wire       last_tick = cnt >= dwell;
  wire       last_row  = int'(row) == ROWS - 1;
  wire       wrap      = run && last_tick && last_row;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg[6:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      dwell    <= DWELL_W'(DWELL_RST);
      cnt      <= '0;
      row      <= '0;
      sh_plane <= '0;
      sh_inv   <= 1'b0;
    end else begin
      cfg <= cfg_d;
      if (dwell_hit) dwell <= reg_wdata[DWELL_W-1:0];
      if (run) begin
        if (last_tick) begin
          cnt <= '0;
          row <= last_row ? '0 : row + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (!run || wrap) begin
        sh_plane <= pick;
        sh_inv   <= cfg_d[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_hit) mem[reg_addr[RW+1:RW]][reg_addr[RW-1:0]] <= reg_wdata;
  end

  assign row_drv = ROWS'(1) << row;
  assign col_drv = mem[sh_plane][row] ^ {COLS{sh_inv}};
  assign row_oe  = {ROWS{run}};
  assign col_oe  = {COLS{run}};
endmodule

module led_plane_scan_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h0D
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic [AW-1:0]   reg_addr,
  input logic            wr_run,
  input logic [ROWS-1:0] row_drv,
  input logic [ROWS-1:0] row_oe,
  input logic [COLS-1:0] col_oe
);
  a_r4_one_row: assert property (@(posedge clk) disable iff (rst)
    $countones(row_drv) == 1);

  a_r4_next_row: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_drv) |-> row_drv == {$past(row_drv[ROWS-2:0]), $past(row_drv[ROWS-1])});

  a_r2_stop: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == CFG_ADDR && !wr_run) |=> (row_oe == '0 && col_oe == '0));

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == CFG_ADDR && wr_run) |=> (&row_oe && &col_oe));

  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    !row_oe[0] |=> $stable(row_drv));
endmodule

bind led_plane_scan led_plane_scan_chk #(
  .ROWS(ROWS), .COLS(COLS), .AW(AW), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .wr_run(reg_wdata[0]), .row_drv(row_drv), .row_oe(row_oe), .col_oe(col_oe)
);

// File: tb/led_plane_scan_tb.sv
module led_plane_scan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  row_drv, row_oe;
  logic [15:0] col_drv, col_oe;

  int checks = 0;
  int errors = 0;
  int dw = 4;
  bit done = 0;

  always #5 clk = ~clk;

  led_plane_scan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .row_drv(row_drv), .row_oe(row_oe),
    .col_drv(col_drv), .col_oe(col_oe)
  );

  function automatic logic [15:0] pat(int p, int r);
    return {4'(p + 1), 4'(r), 8'hC3 ^ 8'(r * 29 + p * 7)};
  endfunction

  function automatic int row_idx(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_row(logic [7:0] target);
    for (int t = 0; t < 400 && row_drv != target; t++) @(negedge clk);
  endtask

  task automatic frame_sync();
    logic [7:0] prev = row_drv;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (prev == 8'h80 && row_drv == 8'h01) return;
      prev = row_drv;
    end
    check(0, "R4 frame start", {24'h0, row_drv}, 32'h01);
  endtask

  task automatic check_frame(int p, bit inv, string req);
    bit ok = 1;
    logic [15:0] a_col = '0, e_col = '0;
    logic [7:0] a_row = '0, e_row = '0;
    frame_sync();
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < dw; k++) begin
        if (r != 0 || k != 0) @(negedge clk);
        if (ok && (row_drv != 8'(1 << r) || col_drv != (pat(p, r) ^ {16{inv}}) || !(&row_oe))) begin
          ok = 0; a_row = row_drv; e_row = 8'(1 << r);
          a_col = col_drv; e_col = pat(p, r) ^ {16{inv}};
        end
      end
    @(negedge clk);
    if (ok && row_drv != 8'h01) begin ok = 0; a_row = row_drv; e_row = 8'h01; end
    check(ok, req, {a_row, 8'h0, a_col}, {e_row, 8'h0, e_col});
  endtask

  task automatic t_reset();
    check(row_oe == 0 && col_oe == 0, "R1 enables low", {row_oe, col_oe}, 0);
    check(row_drv == 8'h01, "R1 first row", row_drv, 8'h01);
  endtask

  task automatic t_start();
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 8; r++) wr(8'h20 | 8'(p << 3) | 8'(r), pat(p, r));
    wr(8'h0E, 16'd2);
    dw = 3;
    wr(8'h0D, 16'h0001);
    check(&row_oe && &col_oe, "R2 run enables", {row_oe, col_oe}, 24'hFFFFFF);
    check_frame(0, 0, "R4 R5 R6 plane0 scan");
  endtask

  task automatic t_planes();
    wr(8'h0D, 16'h0005); check_frame(1, 0, "R8 code1");
    wr(8'h0D, 16'h0009); check_frame(2, 0, "R8 code2");
    wr(8'h0D, 16'h000D); check_frame(3, 0, "R8 code3");
    wr(8'h0D, 16'h0089); check_frame(0, 0, "R8 fold code2");
    wr(8'h0D, 16'h008D); check_frame(1, 0, "R8 fold code3");
  endtask

  task automatic t_invert();
    wr(8'h0D, 16'h000B); check_frame(2, 1, "R7 inverted plane2");
  endtask

  task automatic t_tear();
    bit ok = 1;
    logic [15:0] a = '0, e = '0;
    wait_row(8'h08);
    wr(8'h0D, 16'h0005);
    for (int t = 0; t < 100 && row_drv != 8'h01; t++) begin
      if (ok && col_drv != ~pat(2, row_idx(row_drv))) begin
        ok = 0; a = col_drv; e = ~pat(2, row_idx(row_drv));
      end
      @(negedge clk);
    end
    check(ok, "R9 old frame kept", a, e);
    check(col_drv == pat(1, 0), "R9 new frame start", col_drv, pat(1, 0));
    check_frame(1, 0, "R9 new setting");
  endtask

  task automatic t_shutdown();
    logic [7:0] held;
    bit ok = 1;
    wait_row(8'h10);
    wr(8'h0D, 16'h0004);
    check(row_oe == 0 && col_oe == 0, "R2 stop enables", {row_oe, col_oe}, 0);
    held = row_drv;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (row_drv != held || row_oe != 0) ok = 0;
    end
    check(ok, "R3 scan frozen", row_drv, held);
    wr(8'h0D, 16'h0005);
    check(row_drv == held && &row_oe, "R3 resume row", row_drv, held);
    check(col_drv == pat(1, row_idx(held)), "R3 setting kept", col_drv, pat(1, row_idx(held)));
    check_frame(1, 0, "R3 plane and dwell kept");
    wait_row(8'h20);
    wr(8'h0D, 16'h0004);
    wr(8'h0D, 16'h000A);
    wr(8'h0D, 16'h000B);
    check(row_drv == 8'h20, "R3 resume row2", row_drv, 8'h20);
    check(col_drv == ~pat(2, 5), "R9 shutdown change at once", col_drv, ~pat(2, 5));
    check_frame(2, 1, "R9 shutdown change frame");
  endtask

  task automatic t_ignore();
    wr(8'h05, 16'h0000);
    wr(8'h0C, 16'h0000);
    wr(8'h0F, 16'h0000);
    wr(8'h40, 16'h0000);
    check(&row_oe && &col_oe, "R10 enables unchanged", {row_oe, col_oe}, 24'hFFFFFF);
    check_frame(2, 1, "R10 display unchanged");
  endtask

  task automatic t_dwell();
    wr(8'h0E, 16'd0);
    dw = 1;
    check_frame(2, 1, "R5 dwell one cycle");
    wr(8'h0E, 16'd5);
    dw = 6;
    check_frame(2, 1, "R5 dwell six cycles");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_planes();
    t_invert();
    t_tear();
    t_shutdown();
    t_ignore();
    t_dwell();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule